// File: doc/BRIEF.md
# Serial PROM Marker-Locked Byte Reader

This block pulls user data out of a serial configuration PROM, from the region that follows the configuration bitstream. It drives the PROM clock and the PROM reset/output-enable pin, and it samples the PROM's serial data line. After a restart it scans the incoming bit stream for a fixed marker that is 2^LEN_LOG2 bits wide and supplied on an input port. When it finds the marker, it stops the PROM clock and waits for the host.

The host talks to the block with single-cycle active-low pulses. A read pulse clocks exactly one byte out of the PROM. The byte appears on `dout_o` and is announced by a one-cycle low pulse on `data_ready_no`. A re-scan pulse sends the reader back to hunt for a later copy of the marker. A one-cycle low pulse on `sync_no` reports every marker found. The PROM clock comes from the system clock through a divider sized from the `CLK_MHZ` and `PROM_MHZ` parameters.

Top module: `prom_reader`

## Requirements
- R1: While `rst_ni` is low, `prom_rst_o` is 1, `prom_clk_o` is 0, and `sync_no` and `data_ready_no` are 1.
- R2: `restart_i` high drives `prom_rst_o` high from the next cycle onward. Once `restart_i` and `prom_rst_o` have both dropped, the marker scan starts again from the first bit the PROM delivers.
- R3: The PROM clock spends exactly HALF = ceil(CLK_MHZ / (2*PROM_MHZ)) system cycles in each phase while it runs (3 cycles with the defaults). `din_i` is sampled in the system cycle in which `prom_clk_o` rises.
- R4: During the scan, each sampled bit enters the low end of a shift window, so the first bit received is the most significant. A match is declared only when at least 2^LEN_LOG2 bits have been received since the scan started and the window equals `sync_pattern_i` exactly. A pattern that differs in a single bit does not match.
- R5: A match produces one low cycle on `sync_no`, in the cycle after the sample that completed the marker. The PROM has then delivered exactly the bits up to the end of the marker.
- R6: After a match, and after each byte, `prom_clk_o` completes its high phase, returns to 0, and stays at 0 until the next read or re-scan request. No PROM bit is consumed while the block waits.
- R7: A low cycle on `rd_ni` while the block waits clocks in exactly 8 bits, most significant first. `dout_o` then shows that byte, and `data_ready_no` goes low for exactly one cycle, in the same cycle that `dout_o` changes.
- R8: `rd_ni` pulses that arrive while the block is scanning are ignored. They produce no `data_ready_no` pulse and no change in how many bits the scan consumes.
- R9: `dout_o` keeps its last byte until the next byte completes.
- R10: A low cycle on `next_sync_ni` while the block waits clears the window and starts a fresh scan, so a marker is only recognised after a full 2^LEN_LOG2 new bits. If `next_sync_ni` and `rd_ni` are low in the same cycle, `next_sync_ni` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Synchronous reader restart, active high |
| rd_ni | input | 1 | Byte request, one-cycle active-low pulse |
| next_sync_ni | input | 1 | Re-scan request, one-cycle active-low pulse |
| din_i | input | 1 | Serial data from the PROM |
| sync_pattern_i | input | 2^LEN_LOG2 | Marker to search for |
| prom_clk_o | output | 1 | Clock to the PROM |
| prom_rst_o | output | 1 | PROM reset/output enable, high holds the PROM in reset |
| sync_no | output | 1 | Marker found, one-cycle active-low pulse |
| data_ready_no | output | 1 | Byte valid on dout_o, one-cycle active-low pulse |
| dout_o | output | 8 | Last byte read |

## Verification
The assertions assume that `rd_ni` and `next_sync_ni` are single-cycle pulses. They also assume that `sync_pattern_i` stays constant for the whole scan, and that the PROM advances its data line only after a rising edge of `prom_clk_o`. The bench models the PROM as a bit array indexed by a counter. The counter advances on each rising PROM clock and clears while `prom_rst_o` is high. Host pulses are sent one cycle wide on falling system edges, and the pattern input is held constant. The bit counter lets every check compare the number of consumed bits exactly.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_WAIT   = 2'd1,
    ST_BYTE   = 2'd2
  } rd_state_e;

  function automatic int half_period(input int clk_mhz, input int prom_mhz);
    return (clk_mhz + 2 * prom_mhz - 1) / (2 * prom_mhz);
  endfunction
endpackage

// File: rtl/prom_clk_div.sv
module prom_clk_div #(
  parameter int HALF = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = run_i && (cnt_q == CW'(HALF - 1));
  assign rise_o = wrap && !sclk_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else if (run_i) begin
      if (wrap) begin
        cnt_q  <= '0;
        sclk_o <= ~sclk_o;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_RISE_GOES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o && !clr_i) |=> sclk_o); // R3
endmodule

// File: rtl/prom_sync_detect.sv
module prom_sync_detect #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  input  logic [W-1:0] pattern_i,
  output logic         hit_o
);
  localparam int FW = $clog2(W) + 1;

  logic [W-2:0]  win_q;
  logic [W-1:0]  win_nxt;
  logic [FW-1:0] fill_q;
  logic          full_nxt;

  assign win_nxt  = {win_q, bit_i};
  assign full_nxt = (fill_q >= FW'(W - 1));
  assign hit_o    = shift_i && full_nxt && (win_nxt == pattern_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (clr_i) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (shift_i) begin
      win_q <= win_nxt[W-2:0];
      if (fill_q != FW'(W)) fill_q <= fill_q + 1'b1;
    end
  end

  AST_NO_HIT_AFTER_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !hit_o); // R4
endmodule

// File: rtl/prom_byte_shift.sv
module prom_byte_shift #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic          done_o,
  output logic [BW-1:0] byte_o
);
  localparam int CW = $clog2(BW);

  logic [BW-2:0] sr_q;
  logic [CW-1:0] cnt_q;

  assign byte_o = {sr_q, bit_i};
  assign done_o = shift_i && (cnt_q == CW'(BW - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
    end else if (shift_i) begin
      sr_q  <= byte_o[BW-2:0];
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end

  AST_START_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !shift_i) |=> !done_o); // R7
endmodule

// File: rtl/prom_reader.sv
module prom_reader
  import prom_rd_pkg::*;
#(
  parameter int LEN_LOG2 = 5,
  parameter int CLK_MHZ  = 50,
  parameter int PROM_MHZ = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       restart_i,
  input  logic                       rd_ni,
  input  logic                       next_sync_ni,
  input  logic                       din_i,
  input  logic [(1<<LEN_LOG2)-1:0]   sync_pattern_i,
  output logic                       prom_clk_o,
  output logic                       prom_rst_o,
  output logic                       sync_no,
  output logic                       data_ready_no,
  output logic [7:0]                 dout_o
);
  localparam int PAT_W = 1 << LEN_LOG2;
  localparam int HALF  = half_period(CLK_MHZ, PROM_MHZ);

  rd_state_e  state_q, state_d;
  logic       tick, hit, done, run;
  logic       det_clr, byte_start;
  logic [7:0] byte_w;

  // clock only runs while scanning/shifting, or to finish a high phase
  assign run = !prom_rst_o && !restart_i && ((state_q != ST_WAIT) || prom_clk_o);

  assign det_clr    = restart_i || ((state_q == ST_WAIT) && !next_sync_ni);
  assign byte_start = (state_q == ST_WAIT) && !rd_ni && next_sync_ni;

  prom_clk_div #(.HALF(HALF)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart_i),
    .run_i  (run),
    .sclk_o (prom_clk_o),
    .rise_o (tick)
  );

  prom_sync_detect #(.W(PAT_W)) u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (det_clr),
    .shift_i   (tick && (state_q == ST_SEARCH)),
    .bit_i     (din_i),
    .pattern_i (sync_pattern_i),
    .hit_o     (hit)
  );

  prom_byte_shift #(.BW(8)) u_byte (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (byte_start),
    .shift_i (tick && (state_q == ST_BYTE)),
    .bit_i   (din_i),
    .done_o  (done),
    .byte_o  (byte_w)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SEARCH: if (hit) state_d = ST_WAIT;
      ST_WAIT: begin
        if (!next_sync_ni) state_d = ST_SEARCH;
        else if (!rd_ni)   state_d = ST_BYTE;
      end
      ST_BYTE:   if (done) state_d = ST_WAIT;
      default:   state_d = ST_SEARCH;
    endcase
    if (restart_i) state_d = ST_SEARCH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_SEARCH;
      prom_rst_o    <= 1'b1;
      sync_no       <= 1'b1;
      data_ready_no <= 1'b1;
      dout_o        <= '0;
    end else begin
      state_q       <= state_d;
      prom_rst_o    <= restart_i;
      sync_no       <= !(hit && !restart_i);
      data_ready_no <= !(done && !restart_i);
      if (done && !restart_i) dout_o <= byte_w;
    end
  end

  AST_SYNC_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_no |=> sync_no); // R5
  AST_READY_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_ready_no |=> data_ready_no); // R7
  AST_PROM_RST_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> prom_rst_o); // R2
  AST_CLK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !prom_clk_o && rd_ni && next_sync_ni && !restart_i)
      |=> !prom_clk_o); // R6
  AST_NO_READY_SEARCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEARCH) |=> data_ready_no); // R8
  AST_DOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_BYTE) |=> $stable(dout_o)); // R9
endmodule

// File: tb/prom_reader_tb_top.sv
module prom_reader_tb_top;
  localparam int CLK_PERIOD = 20;
  localparam int HALF_EXP   = 3;
  localparam logic [31:0] PAT  = 32'h8F9FAFBF;
  localparam logic [31:0] NEAR = 32'h8F9FAFBE;
  localparam int NBYTES = 5;
  localparam logic [7:0] BYTE_TAB [NBYTES] = '{8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h81};

  logic clk_i = 1'b0, rst_ni = 1'b0, restart_i = 1'b0;
  logic rd_ni = 1'b1, next_sync_ni = 1'b1, din_i;
  logic prom_clk_o, prom_rst_o, sync_no, data_ready_no;
  logic [7:0] dout_o;

  int total = 0, bad = 0;
  logic stream [0:255];
  int pos = 0, idx = 0, stray = 0;
  bit watch_search = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  prom_reader dut_i (
    .clk_i, .rst_ni, .restart_i, .rd_ni, .next_sync_ni, .din_i,
    .sync_pattern_i(PAT), .prom_clk_o, .prom_rst_o, .sync_no,
    .data_ready_no, .dout_o
  );

  // behavioural PROM: next bit after each rising clock
  assign din_i = stream[idx & 255];
  always @(posedge prom_clk_o or posedge prom_rst_o)
    if (prom_rst_o) idx <= 0; else idx <= idx + 1;

  always @(negedge clk_i) if (watch_search && !data_ready_no) stray++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      stream[pos] = v[i];
      pos++;
    end
  endtask

  task automatic wait_sync(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 4000 && !seen; k++) begin
      @(negedge clk_i);
      if (!sync_no) seen = 1'b1;
    end
  endtask

  task automatic read_byte(output logic [7:0] b, output int used, output bit ok, output bit width1);
    int i0;
    i0 = idx;
    ok = 1'b0;
    @(negedge clk_i) rd_ni = 1'b0;
    @(negedge clk_i) rd_ni = 1'b1;
    for (int k = 0; k < 400 && !ok; k++) begin
      if (!data_ready_no) ok = 1'b1;
      else @(negedge clk_i);
    end
    b = dout_o;
    used = idx - i0;
    @(negedge clk_i);
    width1 = data_ready_no;
  endtask

  initial begin
    bit seen, ok, w1;
    logic [7:0] b;
    int used, hi, lo, c0, i0;
    for (int i = 0; i < 256; i++) stream[i] = 1'b0;
    push(32'b10110, 5);
    push(NEAR, 32);
    push(PAT, 32);
    for (int i = 0; i < NBYTES; i++) push({24'h0, BYTE_TAB[i]}, 8);
    push(32'b1100101, 7);
    push(PAT, 32);
    push(32'h5A, 8);

    // R1 reset state
    repeat (3) @(negedge clk_i);
    check(prom_rst_o == 1'b1, "R1 prom_rst", prom_rst_o, 1);
    check(prom_clk_o == 1'b0, "R1 prom_clk", prom_clk_o, 0);
    check(sync_no == 1'b1, "R1 sync_no", sync_no, 1);
    check(data_ready_no == 1'b1, "R1 data_ready_no", data_ready_no, 1);
    rst_ni = 1'b1;
    watch_search = 1'b1;

    // R3 phase lengths
    for (int k = 0; k < 100 && !prom_clk_o; k++) @(negedge clk_i);
    hi = 0;
    while (prom_clk_o && hi < 100) begin hi++; @(negedge clk_i); end
    lo = 0;
    while (!prom_clk_o && lo < 100) begin lo++; @(negedge clk_i); end
    check(hi == HALF_EXP, "R3 high phase", hi, HALF_EXP);
    check(lo == HALF_EXP, "R3 low phase", lo, HALF_EXP);

    // R8 read during scan ignored
    @(negedge clk_i) rd_ni = 1'b0;
    @(negedge clk_i) rd_ni = 1'b1;

    // R4/R5 marker after near miss
    wait_sync(seen);
    watch_search = 1'b0;
    check(seen && idx == 69, "R4 bits at sync", idx, 69);
    check(stray == 0, "R8 ready while scanning", stray, 0);
    @(negedge clk_i);
    check(sync_no == 1'b1, "R5 sync width", sync_no, 1);

    // R6 clock held while waiting
    repeat (10) @(negedge clk_i);
    i0 = idx; c0 = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk_i);
      if (prom_clk_o) c0++;
    end
    check(c0 == 0 && idx == i0, "R6 clock held", idx - i0 + c0, 0);

    // R7 byte table
    for (int i = 0; i < NBYTES; i++) begin
      read_byte(b, used, ok, w1);
      check(ok && b == BYTE_TAB[i], "R7 byte value", b, BYTE_TAB[i]);
      check(used == 8, "R7 bits per byte", used, 8);
      check(w1, "R7 ready width", w1, 1);
    end

    // R9 dout holds
    repeat (40) @(negedge clk_i);
    check(dout_o == 8'h81, "R9 dout hold", dout_o, 8'h81);

    // R10 re-scan
    @(negedge clk_i) next_sync_ni = 1'b0;
    @(negedge clk_i) next_sync_ni = 1'b1;
    wait_sync(seen);
    check(seen && idx == 148, "R10 bits at resync", idx, 148);
    read_byte(b, used, ok, w1);
    check(ok && b == 8'h5A, "R10 byte after resync", b, 8'h5A);

    // R2 restart
    @(negedge clk_i) restart_i = 1'b1;
    @(negedge clk_i);
    check(prom_rst_o == 1'b1, "R2 prom_rst high", prom_rst_o, 1);
    @(negedge clk_i) restart_i = 1'b0;
    watch_search = 1'b1;
    wait_sync(seen);
    check(seen && idx == 69, "R2 bits after restart", idx, 69);
    read_byte(b, used, ok, w1);
    check(ok && b == 8'hA5, "R2 first byte after restart", b, 8'hA5);

    // R10 re-scan wins over simultaneous read
    stray = 0;
    @(negedge clk_i) begin next_sync_ni = 1'b0; rd_ni = 1'b0; end
    @(negedge clk_i) begin next_sync_ni = 1'b1; rd_ni = 1'b1; end
    wait_sync(seen);
    check(seen && idx == 148, "R10 precedence resync", idx, 148);
    check(stray == 0, "R10 no byte on precedence", stray, 0);
    watch_search = 1'b0;
    read_byte(b, used, ok, w1);
    check(ok && b == 8'h5A, "R10 byte after precedence", b, 8'h5A);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL R1 watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule